// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

A chain of `STAGES` single-bit static storage stages (32 by default) that moves its contents by one position on each rising clock edge, toward the high end or toward the low end. Stage 1 is the low end and stage `STAGES` is the high end. A mode input decides what enters the vacated end stage: a bit from the serial input at that end, or the bit that is leaving the opposite end, which turns the chain into a rotator. A hold input freezes the whole chain for that edge.

The two end stages are copied into output registers on the falling clock edge. This gives a half-cycle presentation delay, which is how the slave half of a master-slave stage behaves. Because each end has both a serial input and an output, two or more copies can be chained into one longer register. To do this, wire the high-end output of one copy to the low-end serial input of the next, and the low-end output of the next copy back to the high-end serial input of the one before. A synchronous active-high reset clears every stage and both output registers.

Top module: `bidir_recirc_shreg`

## Requirements
- R1: While `rst` is high at a rising edge, every stage is cleared to 0. While `rst` is high at a falling edge, `out_lo` and `out_hi` are cleared to 0.
- R2: When `hold_en` is 1 at a rising edge, no stage changes, whatever the other inputs are. `out_lo` and `out_hi` keep their values.
- R3: With `hold_en`=0, `dir_left`=0 and `ext_sel`=1, each stage k+1 takes the old value of stage k, and stage 1 takes `ser_in_r`.
- R4: With `hold_en`=0, `dir_left`=0 and `ext_sel`=0, the chain moves as in R3, except that stage 1 takes the old value of stage `STAGES`, so the contents rotate.
- R5: With `hold_en`=0, `dir_left`=1 and `ext_sel`=1, each stage k takes the old value of stage k+1, and stage `STAGES` takes `ser_in_l`.
- R6: With `hold_en`=0, `dir_left`=1 and `ext_sel`=0, the chain moves as in R5, except that stage `STAGES` takes the old value of stage 1.
- R7: `out_lo` presents stage 1 and `out_hi` presents stage `STAGES`. Both are updated on the falling edge, so a bit that enters an end stage at a rising edge does not appear at the output until the falling edge that follows.
- R8: Control and data inputs act only through their values at the rising edge. Changes while the clock is low that are undone before that edge have no effect. The controls must not change while the clock is high.
- R9: Two copies wired end to end through their serial pins, with shared controls and `ext_sel`=1, behave as one chain of 2×`STAGES` stages in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Stages move on the rising edge; end outputs update on the falling edge |
| rst | input | 1 | Synchronous active-high clear |
| dir_left | input | 1 | 0 = move toward stage `STAGES`, 1 = move toward stage 1 |
| ext_sel | input | 1 | 1 = entry bit from the serial input, 0 = entry bit wraps from the far end |
| hold_en | input | 1 | 1 = freeze the chain at this rising edge |
| ser_in_r | input | 1 | Serial bit entering stage 1 when moving toward the high end |
| ser_in_l | input | 1 | Serial bit entering stage `STAGES` when moving toward the low end |
| out_lo | output | 1 | Stage 1, re-timed to the falling edge |
| out_hi | output | 1 | Stage `STAGES`, re-timed to the falling edge |

## Verification
A move takes effect at a rising edge, but the ports show it only after the falling edge half a cycle later. The bench therefore drives inputs just after a falling edge and samples both outputs just after the next falling edge, where they reflect that rising edge. In the half-cycle test the bench also samples just after the rising edge, and at that point it expects the old end value to still be visible. Bits deep inside the chain appear at the ports only after they are moved to an end. The bench therefore follows every load with full rotations, and compares both ends against a queue model at each step. In the cascaded pair, each bit crosses between the copies with one rising edge of delay, which is exactly one stage of the combined chain.

// File: rtl/bdsr_pkg.sv
package bdsr_pkg;

    typedef enum logic [1:0] {
        MOVE_HOLD  = 2'd0,
        MOVE_RIGHT = 2'd1,
        MOVE_LEFT  = 2'd2
    } move_e;

    // Hold has priority over direction.
    function automatic move_e decode_move(input logic hold, input logic left);
        if (hold)
            return MOVE_HOLD;
        else if (left)
            return MOVE_LEFT;
        else
            return MOVE_RIGHT;
    endfunction

endpackage

// File: rtl/bdsr_ctrl_dec.sv
module bdsr_ctrl_dec
    import bdsr_pkg::*;
(
    input  logic  hold_en,
    input  logic  dir_left,
    output move_e move
);

    always_comb begin
        move = decode_move(hold_en, dir_left);
    end

endmodule

// File: rtl/bdsr_feed_sel.sv
module bdsr_feed_sel (
    input  logic ext_sel,
    input  logic ser_in_r,
    input  logic ser_in_l,
    input  logic end_lo,
    input  logic end_hi,
    output logic feed_r,
    output logic feed_l
);

    // Entry bit for each direction: external serial input or wrap from far end.
    always_comb begin
        feed_r = ext_sel ? ser_in_r : end_hi;
        feed_l = ext_sel ? ser_in_l : end_lo;
    end

endmodule

// File: rtl/bdsr_chain.sv
module bdsr_chain
    import bdsr_pkg::*;
#(
    parameter int STAGES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  move_e             move,
    input  logic              feed_r,
    input  logic              feed_l,
    output logic [STAGES-1:0] stage_q
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] stg;
    } chain_s;

    chain_s            chain_d, chain_q;
    logic [STAGES-1:0] from_lo;
    logic [STAGES-1:0] from_hi;

    // Neighbour each stage takes in either direction.
    for (genvar i = 0; i < STAGES; i++) begin : g_nb
        if (i == 0) begin : g_first
            assign from_lo[i] = feed_r;
        end else begin : g_mid_lo
            assign from_lo[i] = chain_q.stg[i-1];
        end
        if (i == LAST) begin : g_last
            assign from_hi[i] = feed_l;
        end else begin : g_mid_hi
            assign from_hi[i] = chain_q.stg[i+1];
        end
    end

    always_comb begin
        chain_d = chain_q;
        if (rst) begin
            chain_d.stg = '0;
        end else begin
            unique case (move)
                MOVE_RIGHT: chain_d.stg = from_lo;
                MOVE_LEFT:  chain_d.stg = from_hi;
                default:    chain_d.stg = chain_q.stg;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign stage_q = chain_q.stg;

endmodule

// File: rtl/bdsr_end_retime.sv
module bdsr_end_retime (
    input  logic clk,
    input  logic rst,
    input  logic end_lo,
    input  logic end_hi,
    output logic out_lo,
    output logic out_hi
);

    typedef struct packed {
        logic lo;
        logic hi;
    } ends_s;

    ends_s ends_d, ends_q;

    always_comb begin
        if (rst) begin
            ends_d = '0;
        end else begin
            ends_d.lo = end_lo;
            ends_d.hi = end_hi;
        end
    end

    // Slave half: capture on the falling edge.
    always_ff @(negedge clk) begin
        ends_q <= ends_d;
    end

    assign out_lo = ends_q.lo;
    assign out_hi = ends_q.hi;

endmodule

// File: rtl/bidir_recirc_shreg.sv
module bidir_recirc_shreg
    import bdsr_pkg::*;
#(
    parameter int STAGES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic dir_left,
    input  logic ext_sel,
    input  logic hold_en,
    input  logic ser_in_r,
    input  logic ser_in_l,
    output logic out_lo,
    output logic out_hi
);

    localparam int LAST = STAGES - 1;

    move_e             move;
    logic              feed_r;
    logic              feed_l;
    logic [STAGES-1:0] stage_q;

    bdsr_ctrl_dec u_dec (
        .hold_en  (hold_en),
        .dir_left (dir_left),
        .move     (move)
    );

    bdsr_feed_sel u_feed (
        .ext_sel  (ext_sel),
        .ser_in_r (ser_in_r),
        .ser_in_l (ser_in_l),
        .end_lo   (stage_q[0]),
        .end_hi   (stage_q[LAST]),
        .feed_r   (feed_r),
        .feed_l   (feed_l)
    );

    bdsr_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .move    (move),
        .feed_r  (feed_r),
        .feed_l  (feed_l),
        .stage_q (stage_q)
    );

    bdsr_end_retime u_ret (
        .clk    (clk),
        .rst    (rst),
        .end_lo (stage_q[0]),
        .end_hi (stage_q[LAST]),
        .out_lo (out_lo),
        .out_hi (out_hi)
    );

endmodule

// File: rtl/bdsr_chk.sv
module bdsr_chk #(
    parameter int STAGES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dir_left,
    input logic              ext_sel,
    input logic              hold_en,
    input logic              ser_in_r,
    input logic              ser_in_l,
    input logic [STAGES-1:0] stage_q,
    input logic              out_lo,
    input logic              out_hi
);

    localparam int LAST = STAGES - 1;

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> stage_q == '0);  // R1

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold_en |=> $stable(stage_q));  // R2

    AST_SHR_EXT: assert property (@(posedge clk) disable iff (rst)
        (!hold_en && !dir_left && ext_sel) |=>
            (stage_q[0] == $past(ser_in_r)) &&
            (stage_q[LAST:1] == $past(stage_q[LAST-1:0])));  // R3

    AST_SHR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!hold_en && !dir_left && !ext_sel) |=>
            (stage_q == {$past(stage_q[LAST-1:0]), $past(stage_q[LAST])}));  // R4

    AST_SHL_EXT: assert property (@(posedge clk) disable iff (rst)
        (!hold_en && dir_left && ext_sel) |=>
            (stage_q[LAST] == $past(ser_in_l)) &&
            (stage_q[LAST-1:0] == $past(stage_q[LAST:1])));  // R5

    AST_SHL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!hold_en && dir_left && !ext_sel) |=>
            (stage_q == {$past(stage_q[0]), $past(stage_q[LAST:1])}));  // R6

    AST_ENDS_RETIMED: assert property (@(posedge clk) disable iff (rst)
        (out_lo == stage_q[0]) && (out_hi == stage_q[LAST]));  // R7

    always @(dir_left or ext_sel or hold_en) begin
        AST_CTRL_STABLE_HI: assert (!(clk === 1'b1 && rst === 1'b0))
            else $error("control changed while clock high");  // R8
    end

endmodule

bind bidir_recirc_shreg bdsr_chk #(.STAGES(STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dir_left (dir_left),
    .ext_sel  (ext_sel),
    .hold_en  (hold_en),
    .ser_in_r (ser_in_r),
    .ser_in_l (ser_in_l),
    .stage_q  (stage_q),
    .out_lo   (out_lo),
    .out_hi   (out_hi)
);

// File: tb/bidir_recirc_shreg_tb.sv
`timescale 1ns/1ps
module bidir_recirc_shreg_tb;

    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_left = 1'b0, ext_sel = 1'b1, hold_en = 1'b0;
    logic ser_in_r = 1'b0, ser_in_l = 1'b0;
    logic out_lo, out_hi;

    logic c_dir = 1'b0, c_hold = 1'b1, c_sr = 1'b0, c_sl = 1'b0;
    logic a_lo, a_hi, b_lo, b_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit mdl[$];
    bit cm[$];
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    bidir_recirc_shreg #(.STAGES(N)) u_dut (
        .clk(clk), .rst(rst), .dir_left(dir_left), .ext_sel(ext_sel),
        .hold_en(hold_en), .ser_in_r(ser_in_r), .ser_in_l(ser_in_l),
        .out_lo(out_lo), .out_hi(out_hi)
    );

    bidir_recirc_shreg #(.STAGES(N)) u_ca (
        .clk(clk), .rst(rst), .dir_left(c_dir), .ext_sel(1'b1),
        .hold_en(c_hold), .ser_in_r(c_sr), .ser_in_l(b_lo),
        .out_lo(a_lo), .out_hi(a_hi)
    );

    bidir_recirc_shreg #(.STAGES(N)) u_cb (
        .clk(clk), .rst(rst), .dir_left(c_dir), .ext_sel(1'b1),
        .hold_en(c_hold), .ser_in_r(a_hi), .ser_in_l(c_sl),
        .out_lo(b_lo), .out_hi(b_hi)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_ends(input string req);
        chk(out_lo, mdl[0], req, "out_lo");
        chk(out_hi, mdl[N-1], req, "out_hi");
    endtask

    // Set inputs (clock low) and advance the reference queue.
    task automatic apply(input bit dl, input bit es, input bit hd, input bit sr, input bit sl);
        bit e;
        dir_left = dl; ext_sel = es; hold_en = hd; ser_in_r = sr; ser_in_l = sl;
        if (!hd) begin
            if (!dl) begin
                e = es ? sr : mdl[N-1];
                mdl.push_front(e);
                void'(mdl.pop_back());
            end else begin
                e = es ? sl : mdl[0];
                mdl.push_back(e);
                void'(mdl.pop_front());
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic step(input bit dl, input bit es, input bit hd, input bit sr, input bit sl,
                        input string req);
        apply(dl, es, hd, sr, sl);
        tick();
        check_ends(req);
    endtask

    task automatic rotate_all(input bit dl, input string req);
        for (int i = 0; i < N; i++) step(dl, 1'b0, 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic t_reset();
        chk(out_lo, 1'b0, "R1", "out_lo after reset");
        chk(out_hi, 1'b0, "R1", "out_hi after reset");
        for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3 fill");
        rst = 1'b1;
        tick();
        rst = 1'b0;
        mdl.delete();
        for (int i = 0; i < N; i++) mdl.push_back(1'b0);
        check_ends("R1");
        rotate_all(1'b0, "R1 cleared contents");
    endtask

    task automatic t_right_ext();
        for (int i = 0; i < N + 4; i++) begin
            lf = lfsr_next(lf);
            step(1'b0, 1'b1, 1'b0, lf[0], lf[1], "R3");
        end
    endtask

    task automatic t_right_rot();
        rotate_all(1'b0, "R4");
        rotate_all(1'b0, "R4");
    endtask

    task automatic t_left_ext();
        for (int i = 0; i < N + 4; i++) begin
            lf = lfsr_next(lf);
            step(1'b1, 1'b1, 1'b0, lf[2], lf[0], "R5");
        end
    endtask

    task automatic t_left_rot();
        rotate_all(1'b1, "R6");
        rotate_all(1'b1, "R6");
    endtask

    task automatic t_hold();
        logic lo0, hi0;
        lo0 = out_lo;
        hi0 = out_hi;
        for (int i = 0; i < 8; i++) begin
            lf = lfsr_next(lf);
            step(lf[0], lf[1], 1'b1, lf[2], lf[3], "R2");
            chk(out_lo, lo0, "R2", "out_lo frozen");
            chk(out_hi, hi0, "R2", "out_hi frozen");
        end
        rotate_all(1'b0, "R2 contents kept");
    endtask

    task automatic t_half_cycle();
        logic old_lo, old_hi;
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 prep");
        old_lo = out_lo;
        apply(1'b0, 1'b1, 1'b0, ~old_lo, 1'b0);
        @(posedge clk);
        #1;
        chk(out_lo, old_lo, "R7", "out_lo before falling edge");
        @(negedge clk);
        #1;
        chk(out_lo, ~old_lo, "R7", "out_lo after falling edge");
        old_hi = out_hi;
        apply(1'b1, 1'b1, 1'b0, 1'b0, ~old_hi);
        @(posedge clk);
        #1;
        chk(out_hi, old_hi, "R7", "out_hi before falling edge");
        @(negedge clk);
        #1;
        chk(out_hi, ~old_hi, "R7", "out_hi after falling edge");
        check_ends("R7");
    endtask

    task automatic t_edge_only();
        for (int i = 0; i < 12; i++) begin
            lf = lfsr_next(lf);
            dir_left = ~lf[0]; ext_sel = ~lf[1]; hold_en = ~lf[4];
            ser_in_r = ~lf[2]; ser_in_l = ~lf[3];
            #0.4;
            hold_en = 1'b0; ser_in_r = lf[3];
            #0.4;
            step(lf[0], lf[1], 1'b0, lf[2], lf[3], "R8");
        end
        rotate_all(1'b0, "R8 contents");
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 300; i++) begin
            lf = lfsr_next(lf);
            step(lf[0], lf[1], (lf[5:3] == 3'd0), lf[2], lf[6], "mixed R3 R4 R5 R6 R2");
        end
    endtask

    task automatic c_step(input bit dl, input bit hd, input bit sr, input bit sl);
        c_dir = dl; c_hold = hd; c_sr = sr; c_sl = sl;
        if (!hd) begin
            if (!dl) begin
                cm.push_front(sr);
                void'(cm.pop_back());
            end else begin
                cm.push_back(sl);
                void'(cm.pop_front());
            end
        end
        tick();
        chk(a_lo, cm[0], "R9", "chain stage 1");
        chk(a_hi, cm[N-1], "R9", "chain stage N");
        chk(b_lo, cm[N], "R9", "chain stage N+1");
        chk(b_hi, cm[2*N-1], "R9", "chain stage 2N");
    endtask

    task automatic t_cascade();
        for (int i = 0; i < 2 * N; i++) cm.push_back(1'b0);
        for (int i = 0; i < 2 * N + 6; i++) begin
            lf = lfsr_next(lf);
            c_step(1'b0, 1'b0, lf[0], lf[1]);
        end
        for (int i = 0; i < 3; i++) c_step(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 2 * N + 6; i++) begin
            lf = lfsr_next(lf);
            c_step(1'b1, 1'b0, lf[2], lf[0]);
        end
        for (int i = 0; i < N; i++) c_step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mdl.push_back(1'b0);
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_right_ext();
        t_right_rot();
        t_left_ext();
        t_left_rot();
        t_hold();
        t_half_cycle();
        t_edge_only();
        t_mixed();
        t_cascade();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule